// File: doc/BRIEF.md
# Auto-Increment Word-Program Engine for an SPI Serial Flash

This block is the device-side command logic of a small SPI serial flash. It watches the chip-select, clock and data-in pins in SPI mode 0 or mode 3. It samples data on rising clock edges and launches read data on falling clock edges. It decodes one-byte opcodes and keeps three state bits: a write-enable latch, a sticky auto-increment program mode and a hardware ready/busy selection. All pins are sampled by the block's own system clock, so the serial clock must be several times slower than the system clock.

Programming works on byte pairs. The first program frame carries a 24-bit start address and two data bytes. Each later frame carries only two more data bytes, and these go to the next two sequential addresses. Each word is committed when chip select rises, and a fixed busy period follows. While the sticky mode is active, only a few opcodes are honoured. The host can learn that a word has finished in two ways: by reading the status byte, or by turning the data-out pin into a live ready/busy level.

The storage is a small parameterized byte array that starts erased. Every address at or above a protection boundary is read-only. A plain read command lets the host inspect the array.

Top module: `aai_flash_core`

## Requirements
- R1: After reset the status byte reads 00h, `so_oe` is 0 and every array byte reads FFh.
- R2: The status read opcode 05h returns a status byte on every data byte of the frame, in which bit 0 is busy, bit 1 is the write-enable latch, bit 6 is the program mode and all other bits are 0. Opcode 06h sets the write-enable latch when the device is idle and outside program mode.
- R3: A program frame (opcode ADh) is ignored when the write-enable latch is clear: the array and the status byte stay unchanged.
- R4: The first program frame is opcode ADh, then three address bytes (most significant first), then two data bytes, all sent MSB first. The first data byte is written to the address with bit 0 forced to 0 and the second to the address with bit 0 forced to 1. After that frame, program mode is set.
- R5: A word is committed when chip select rises. For `TBP_CYCLES` clocks after that point the device is busy, which shows as status bit 0.
- R6: In program mode, a frame of opcode ADh plus two data bytes writes those bytes to the next two sequential addresses after the previous word.
- R7: In program mode, opcodes other than ADh, 05h and 04h are ignored (a read frame does not drive `so_oe`). While busy, every opcode except 05h is ignored.
- R8: Opcode 04h, sent while the device is not busy, clears both the write-enable latch and program mode.
- R9: There is no address wrap. When the busy period ends after a word whose upper byte sits at address `PROT_BASE`-1, program mode and the write-enable latch both clear.
- R10: A first program frame whose word address is at or above `PROT_BASE` is ignored: the array does not change and program mode stays clear.
- R11: Opcode 70h enables the hardware ready/busy output. In program mode with this output enabled, chip select low drives `so_oe`=1 with `so_out`=0 while busy and 1 when ready. Opcode 80h disables the output and is ignored in program mode. `so_oe` is 0 whenever chip select is high.
- R12: A frame that ends off a byte boundary, or with a byte count other than its command needs, has no effect.
- R13: Opcode 03h followed by three address bytes streams array bytes MSB first from consecutive addresses. Addresses beyond the array read FFh.
- R14: Programming can only clear bits: the stored byte becomes the old value AND the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from the host |
| so_out | output | 1 | Serial data or ready/busy level to the host |
| so_oe | output | 1 | Output enable for `so_out`; 0 means high impedance |

## Verification
The embedded assertions check on every cycle the rules that tie state bits together. Program mode never exists without the write-enable latch, and it is entered only while the latch is set. A word commit never targets the protected region, and a new busy period never starts while one is running. Also on every cycle: the ready/busy output is never dropped from inside program mode, and the data-out pin is released whenever chip select is high. Other behaviours can only be shown by the bench's directed scenarios. These are the byte placement with bit 0 split, sequential advance across frames, and the AND-only programming of an already written cell. The scenarios also cover the busy window length seen on the pin, the exit at the protection boundary, and opcodes that are ignored in program mode or while busy.

// File: rtl/aai_pkg.sv
// Package: shared opcode values, status bit positions and a status builder
// for the auto-increment word-program engine. Assumes one-byte opcodes.
package aai_pkg;
    localparam logic [7:0] OP_READ    = 8'h03;
    localparam logic [7:0] OP_WRDI    = 8'h04;
    localparam logic [7:0] OP_RDSR    = 8'h05;
    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_RB_ON   = 8'h70;
    localparam logic [7:0] OP_RB_OFF  = 8'h80;
    localparam logic [7:0] OP_WORDPGM = 8'hAD;

    // Byte counts a frame must have for its command to execute.
    localparam logic [2:0] LEN_SINGLE = 3'd1;
    localparam logic [2:0] LEN_FIRST  = 3'd6;
    localparam logic [2:0] LEN_NEXT   = 3'd3;

    // Builds the status byte: bit0 busy, bit1 write latch, bit6 program mode.
    function automatic logic [7:0] make_status(input logic busy,
                                               input logic wel,
                                               input logic pmode);
        return {1'b0, pmode, 4'b0000, wel, busy};
    endfunction
endpackage

// File: rtl/aai_spi_port.sv
// Serial port: brings the asynchronous SPI pins into the clk domain,
// assembles bytes on rising serial clock edges (modes 0 and 3) and shifts
// a loaded byte out MSB first, changing on falling edges.
// Assumes the serial clock is at least four times slower than clk.
module aai_spi_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       cs_n_i,
    input  logic       si_i,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       cs_active,
    output logic       frame_start,
    output logic       frame_end,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       on_boundary,
    output logic       so_bit
);
    logic [1:0] sck_sync, cs_sync, si_sync;
    logic       sck_q, cs_q;
    logic [2:0] bit_cnt;
    logic [6:0] shift_q;
    logic [7:0] tx_q;
    logic       sck_rise, sck_fall;

    // Two-stage synchronisers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sync <= 2'b00;
            cs_sync  <= 2'b11;
            si_sync  <= 2'b00;
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
        end else begin
            sck_sync <= {sck_sync[0], sck_i};
            cs_sync  <= {cs_sync[0], cs_n_i};
            si_sync  <= {si_sync[0], si_i};
            sck_q    <= sck_sync[1];
            cs_q     <= cs_sync[1];
        end
    end

    assign cs_active   = ~cs_sync[1];
    assign frame_start = ~cs_sync[1] & cs_q;
    assign frame_end   = cs_sync[1] & ~cs_q;
    assign sck_rise    = cs_active & sck_sync[1] & ~sck_q;
    assign sck_fall    = cs_active & ~sck_sync[1] & sck_q;
    assign on_boundary = (bit_cnt == 3'd0);

    // Receive: shift on rising edges, flag each completed byte for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= 3'd0;
            shift_q  <= 7'd0;
            rx_valid <= 1'b0;
            rx_byte  <= 8'd0;
        end else begin
            rx_valid <= 1'b0;
            if (frame_start) begin
                bit_cnt <= 3'd0;
            end else if (sck_rise) begin
                shift_q <= {shift_q[5:0], si_sync[1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {shift_q, si_sync[1]};
                end
            end
        end
    end

    // Transmit: a load presents bit 7 at once; each falling edge moves on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= 8'd0;
            so_bit <= 1'b0;
        end else if (frame_start) begin
            so_bit <= 1'b0;
        end else if (tx_load) begin
            tx_q   <= tx_byte;
            so_bit <= tx_byte[7];
        end else if (sck_fall) begin
            so_bit <= tx_q[3'd7 - bit_cnt];
        end
    end
endmodule

// File: rtl/aai_prog_timer.sv
// Program timer: holds busy for TBP_CYCLES clocks after a start pulse and
// flags the last busy cycle. Assumes start is only raised while idle.
module aai_prog_timer #(
    parameter int TBP_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TBP_CYCLES + 1);
    logic [CW-1:0] remain;

    // Down-counter: loaded on start, decremented to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (start)          remain <= CW'(TBP_CYCLES);
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
    assign done = (remain == CW'(1));

    p_start_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/aai_mem_array.sv
// Byte array organised as words of two bytes; each word has its own write
// logic. Writes AND into the stored value (erase is out of scope), so a
// cell only ever loses bits. Reset fills every byte with FFh.
module aai_mem_array #(
    parameter int MEM_BYTES = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         prog_en,
    input  logic [$clog2(MEM_BYTES)-2:0] prog_widx,
    input  logic [7:0]                   prog_d0,
    input  logic [7:0]                   prog_d1,
    input  logic [$clog2(MEM_BYTES)-1:0] rd_idx,
    output logic [7:0]                   rd_data
);
    localparam int IDX_W = $clog2(MEM_BYTES);
    localparam int WORDS = MEM_BYTES / 2;

    logic [7:0] lo_w [WORDS];
    logic [7:0] hi_w [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [7:0] lo_q, hi_q;
        // Per-word storage: reset to erased, AND in new data when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= 8'hFF;
                hi_q <= 8'hFF;
            end else if (prog_en && prog_widx == (IDX_W-1)'(g)) begin
                lo_q <= lo_q & prog_d0;
                hi_q <= hi_q & prog_d1;
            end
        end
        assign lo_w[g] = lo_q;
        assign hi_w[g] = hi_q;
    end

    assign rd_data = rd_idx[0] ? hi_w[rd_idx[IDX_W-1:1]] : lo_w[rd_idx[IDX_W-1:1]];
endmodule

// File: rtl/aai_cmd_ctrl.sv
// Command controller: decodes opcodes, collects address and data bytes,
// keeps the write latch, program mode and ready/busy selection, and issues
// word commits on chip-select rise. Assumes PROT_BASE is even and no larger
// than MEM_BYTES.
module aai_cmd_ctrl
    import aai_pkg::*;
#(
    parameter int MEM_BYTES = 256,
    parameter int PROT_BASE = 192
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_start,
    input  logic                         frame_end,
    input  logic                         rx_valid,
    input  logic [7:0]                   rx_byte,
    input  logic                         on_boundary,
    input  logic                         busy,
    input  logic                         timer_done,
    input  logic [7:0]                   rd_data,
    output logic                         tx_load,
    output logic [7:0]                   tx_byte,
    output logic                         tx_en,
    output logic [$clog2(MEM_BYTES)-1:0] rd_idx,
    output logic                         prog_en,
    output logic [$clog2(MEM_BYTES)-2:0] prog_widx,
    output logic [7:0]                   prog_d0,
    output logic [7:0]                   prog_d1,
    output logic                         wel,
    output logic                         pmode,
    output logic                         rb_en,
    output logic                         rb_live
);
    localparam int IDX_W = $clog2(MEM_BYTES);
    localparam logic [23:0] PROT_LIM  = 24'(PROT_BASE);
    localparam logic [23:0] ARRAY_LIM = 24'(MEM_BYTES);

    logic [7:0]  opcode;
    logic [2:0]  nbytes;
    logic [23:0] addr_q;
    logic [23:0] next_word;
    logic [23:0] prog_waddr;
    logic [23:0] rd_ptr;
    logic [23:0] rd_full;
    logic [23:0] word_base;
    logic        rd_ok;
    logic        last_word;
    logic        stat_now, read_now;
    logic [2:0]  d0_pos;

    assign rb_live   = rb_en & pmode;
    assign word_base = {addr_q[23:1], 1'b0};
    assign d0_pos    = pmode ? 3'd1 : 3'd4;

    // Read pointer: the third address byte completes it, else stream on.
    assign rd_full  = (nbytes == 3'd3) ? {addr_q[15:0], rx_byte} : rd_ptr;
    assign rd_idx   = rd_full[IDX_W-1:0];

    assign stat_now = (nbytes == 3'd0) ? (rx_byte == OP_RDSR) : (opcode == OP_RDSR);
    assign read_now = (nbytes >= 3'd3) && (opcode == OP_READ) && rd_ok;
    assign tx_load  = rx_valid & ((stat_now & ~rb_live) | read_now);

    // Transmit byte: status, array data, or erased value past the array.
    always_comb begin
        if (stat_now)                tx_byte = make_status(busy, wel, pmode);
        else if (rd_full >= ARRAY_LIM) tx_byte = 8'hFF;
        else                         tx_byte = rd_data;
    end

    // Frame capture: opcode, byte count, address, data and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode  <= 8'h00;
            nbytes  <= 3'd0;
            addr_q  <= 24'd0;
            prog_d0 <= 8'hFF;
            prog_d1 <= 8'hFF;
            rd_ptr  <= 24'd0;
            rd_ok   <= 1'b0;
            tx_en   <= 1'b0;
        end else if (frame_start) begin
            nbytes <= 3'd0;
            tx_en  <= 1'b0;
        end else begin
            if (tx_load) tx_en <= 1'b1;
            if (rx_valid) begin
                if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
                if (nbytes == 3'd0) begin
                    opcode <= rx_byte;
                    rd_ok  <= (rx_byte == OP_READ) && !pmode && !busy;
                end else begin
                    if (nbytes <= 3'd3 &&
                        (opcode == OP_READ || (opcode == OP_WORDPGM && !pmode)))
                        addr_q <= {addr_q[15:0], rx_byte};
                    if (opcode == OP_WORDPGM && nbytes == d0_pos)
                        prog_d0 <= rx_byte;
                    if (opcode == OP_WORDPGM && nbytes == d0_pos + 3'd1)
                        prog_d1 <= rx_byte;
                end
                if (read_now) rd_ptr <= rd_full + 24'd1;
            end
        end
    end

    // Command execution on chip-select rise, plus boundary exit after busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel        <= 1'b0;
            pmode      <= 1'b0;
            rb_en      <= 1'b0;
            prog_en    <= 1'b0;
            prog_waddr <= 24'd0;
            next_word  <= 24'd0;
            last_word  <= 1'b0;
        end else begin
            prog_en <= 1'b0;
            if (timer_done && last_word) begin
                pmode     <= 1'b0;
                wel       <= 1'b0;
                last_word <= 1'b0;
            end
            if (frame_end && on_boundary && !busy) begin
                unique case (opcode)
                    OP_WREN:  if (nbytes == LEN_SINGLE && !pmode) wel <= 1'b1;
                    OP_WRDI:  if (nbytes == LEN_SINGLE) begin
                        wel   <= 1'b0;
                        pmode <= 1'b0;
                    end
                    OP_RB_ON:  if (nbytes == LEN_SINGLE && !pmode) rb_en <= 1'b1;
                    OP_RB_OFF: if (nbytes == LEN_SINGLE && !pmode) rb_en <= 1'b0;
                    OP_WORDPGM: begin
                        if (wel && !pmode && nbytes == LEN_FIRST && word_base < PROT_LIM) begin
                            prog_en    <= 1'b1;
                            prog_waddr <= word_base;
                            next_word  <= word_base + 24'd2;
                            last_word  <= (word_base + 24'd2 == PROT_LIM);
                            pmode      <= 1'b1;
                        end else if (wel && pmode && nbytes == LEN_NEXT) begin
                            prog_en    <= 1'b1;
                            prog_waddr <= next_word;
                            next_word  <= next_word + 24'd2;
                            last_word  <= (next_word + 24'd2 == PROT_LIM);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign prog_widx = prog_waddr[IDX_W-1:1];

    p_pmode_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pmode |-> wel);
    p_entry_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pmode) |-> $past(wel));
    p_commit_unprotected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (prog_waddr < PROT_LIM));
    p_rb_off_outside_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_en) |-> !$past(pmode));
endmodule

// File: rtl/aai_flash_core.sv
// Top: SPI serial flash command engine with auto-increment word programming,
// a timed busy period, an optional live ready/busy level on the data-out
// pin, and a protected upper region. The data-out pin is split into a value
// and an enable; a pad outside this block makes the tri-state.
module aai_flash_core #(
    parameter int MEM_BYTES  = 256,
    parameter int PROT_BASE  = 192,
    parameter int TBP_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so_out,
    output logic so_oe
);
    localparam int IDX_W = $clog2(MEM_BYTES);

    logic       cs_active, frame_start, frame_end, rx_valid, on_boundary, so_bit;
    logic [7:0] rx_byte, tx_byte, rd_data, prog_d0, prog_d1;
    logic       tx_load, tx_en, prog_en, busy, timer_done;
    logic       wel, pmode, rb_en, rb_live;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-2:0] prog_widx;

    aai_spi_port u_port (
        .clk, .rst_n, .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
        .tx_load, .tx_byte, .cs_active, .frame_start, .frame_end,
        .rx_valid, .rx_byte, .on_boundary, .so_bit
    );

    aai_cmd_ctrl #(.MEM_BYTES(MEM_BYTES), .PROT_BASE(PROT_BASE)) u_ctrl (
        .clk, .rst_n, .frame_start, .frame_end, .rx_valid, .rx_byte,
        .on_boundary, .busy, .timer_done, .rd_data, .tx_load, .tx_byte,
        .tx_en, .rd_idx, .prog_en, .prog_widx, .prog_d0, .prog_d1,
        .wel, .pmode, .rb_en, .rb_live
    );

    aai_prog_timer #(.TBP_CYCLES(TBP_CYCLES)) u_timer (
        .clk, .rst_n, .start(prog_en), .busy, .done(timer_done)
    );

    aai_mem_array #(.MEM_BYTES(MEM_BYTES)) u_mem (
        .clk, .rst_n, .prog_en, .prog_widx, .prog_d0, .prog_d1,
        .rd_idx, .rd_data
    );

    // Pin mux: live ready level in program mode, else shifted data.
    assign so_out = rb_live ? ~busy : so_bit;
    assign so_oe  = cs_active & (rb_live | tx_en);

    p_so_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |-> !so_oe);
    p_rb_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && rb_en && pmode) |-> so_oe);
endmodule

// File: tb/tb_aai_flash_core.sv
`timescale 1ns/1ps
module tb_aai_flash_core;
    localparam int MEM  = 256;
    localparam int PROT = 64;
    localparam int TBP  = 300;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic so_out, so_oe;
    int   n_chk = 0, n_fail = 0;
    logic [7:0] mo [16];
    logic [7:0] mi [16];
    logic       oe_any;
    bit         finished = 0;

    always #4 clk = ~clk;

    aai_flash_core #(.MEM_BYTES(MEM), .PROT_BASE(PROT), .TBP_CYCLES(TBP)) dut (
        .clk, .rst_n, .sck, .cs_n, .si, .so_out, .so_oe
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One SPI frame of n bytes, mode 0; captures SO before each rising edge.
    task automatic xfer(input int n);
        oe_any = 1'b0;
        cs_n = 1'b0;
        tick(6);
        for (int i = 0; i < n; i++) begin
            for (int b = 7; b >= 0; b--) begin
                si = mo[i][b];
                tick(4);
                mi[i][b] = so_out;
                oe_any |= so_oe;
                sck = 1'b1;
                tick(4);
                sck = 1'b0;
            end
        end
        tick(4);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic op1(input logic [7:0] op);
        mo[0] = op;
        xfer(1);
    endtask

    task automatic status(output logic [7:0] s);
        mo[0] = 8'h05; mo[1] = 8'h00;
        xfer(2);
        s = mi[1];
    endtask

    task automatic rd(input logic [23:0] a, output logic [7:0] d);
        mo[0] = 8'h03; mo[1] = a[23:16]; mo[2] = a[15:8]; mo[3] = a[7:0]; mo[4] = 8'h00;
        xfer(5);
        d = mi[4];
    endtask

    task automatic pgm_first(input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1);
        mo[0] = 8'hAD; mo[1] = a[23:16]; mo[2] = a[15:8]; mo[3] = a[7:0];
        mo[4] = d0; mo[5] = d1;
        xfer(6);
    endtask

    task automatic pgm_next(input logic [7:0] d0, input logic [7:0] d1);
        mo[0] = 8'hAD; mo[1] = d0; mo[2] = d1;
        xfer(3);
    endtask

    task automatic wait_idle();
        tick(TBP + 20);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 so_oe idle", {7'd0, so_oe}, 8'h00);
        status(v); check("R1 status after reset", v, 8'h00);
        rd(24'h000000, v); check("R1 erased byte 0", v, 8'hFF);
        rd(24'h0000FF, v); check("R1 erased byte top", v, 8'hFF);
        rd(24'h001000, v); check("R13 beyond array", v, 8'hFF);
    endtask

    task automatic t_no_wel();
        logic [7:0] v;
        pgm_first(24'h000010, 8'h12, 8'h34);
        wait_idle();
        status(v); check("R3 status unchanged", v, 8'h00);
        rd(24'h000010, v); check("R3 array unchanged", v, 8'hFF);
    endtask

    task automatic t_bad_length();
        logic [7:0] v;
        op1(8'h06);
        status(v); check("R2 wren sets bit1", v, 8'h02);
        mo[0] = 8'hAD; mo[1] = 8'h00; mo[2] = 8'h00; mo[3] = 8'h10; mo[4] = 8'h00;
        xfer(5);
        status(v); check("R12 short frame no mode", v, 8'h02);
        rd(24'h000010, v); check("R12 short frame no write", v, 8'hFF);
    endtask

    task automatic t_first_and_next();
        logic [7:0] v;
        pgm_first(24'h000011, 8'hA5, 8'h3C);
        status(v); check("R5 busy right after commit", v, 8'h43);
        wait_idle();
        status(v); check("R5 busy clears, R4 mode set", v, 8'h42);
        mo[0] = 8'h03; mo[1] = 8'h00; mo[2] = 8'h00; mo[3] = 8'h10; mo[4] = 8'h00;
        xfer(5);
        check("R7 read ignored in mode", {7'd0, oe_any}, 8'h00);
        op1(8'h06);
        status(v); check("R7 still in mode", v, 8'h42);
        pgm_next(8'h5A, 8'hC3); wait_idle();
        pgm_next(8'h11, 8'h22); wait_idle();
        op1(8'h04);
        status(v); check("R8 wrdi clears", v, 8'h00);
        rd(24'h000010, v); check("R4 even byte", v, 8'hA5);
        rd(24'h000011, v); check("R4 odd byte", v, 8'h3C);
        rd(24'h000012, v); check("R6 next word lo", v, 8'h5A);
        rd(24'h000015, v); check("R6 third word hi", v, 8'h22);
        mo[0] = 8'h03; mo[1] = 8'h00; mo[2] = 8'h00; mo[3] = 8'h12; mo[4] = 8'h00; mo[5] = 8'h00;
        xfer(6);
        check("R13 stream first", mi[4], 8'h5A);
        check("R13 stream second", mi[5], 8'hC3);
    endtask

    task automatic t_and_program();
        logic [7:0] v;
        op1(8'h06);
        pgm_first(24'h000010, 8'h0F, 8'hF0);
        wait_idle();
        op1(8'h04);
        rd(24'h000010, v); check("R14 and lo", v, 8'h05);
        rd(24'h000011, v); check("R14 and hi", v, 8'h30);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        op1(8'h06);
        pgm_first(24'h000020, 8'h00, 8'h00);
        op1(8'h04);
        wait_idle();
        status(v); check("R7 wrdi during busy ignored", v, 8'h42);
        op1(8'h04);
        status(v); check("R8 wrdi after busy", v, 8'h00);
    endtask

    task automatic t_protect();
        logic [7:0] v;
        op1(8'h06);
        pgm_first(24'(PROT), 8'h00, 8'h00);
        wait_idle();
        status(v); check("R10 protected start ignored", v, 8'h02);
        rd(24'(PROT), v); check("R10 protected byte", v, 8'hFF);
        op1(8'h04);
    endtask

    task automatic t_boundary();
        logic [7:0] v;
        op1(8'h06);
        pgm_first(24'(PROT - 4), 8'h01, 8'h02);
        wait_idle();
        status(v); check("R9 mode before last word", v, 8'h42);
        pgm_next(8'h03, 8'h04);
        wait_idle();
        status(v); check("R9 exit at boundary", v, 8'h00);
        rd(24'(PROT - 1), v); check("R9 last byte written", v, 8'h04);
        rd(24'(PROT), v); check("R9 no wrap past boundary", v, 8'hFF);
    endtask

    task automatic t_ready_busy();
        logic [7:0] v;
        op1(8'h70);
        op1(8'h06);
        pgm_first(24'h000030, 8'hEE, 8'hDD);
        tick(TBP - 30);
        cs_n = 1'b0; tick(5);
        check("R11 busy level oe", {7'd0, so_oe}, 8'h01);
        check("R11 busy level low", {7'd0, so_out}, 8'h00);
        tick(30);
        check("R5 ready after busy window", {7'd0, so_out}, 8'h01);
        cs_n = 1'b1; tick(5);
        check("R11 released on cs high", {7'd0, so_oe}, 8'h00);
        tick(10);
        op1(8'h80);
        cs_n = 1'b0; tick(6);
        check("R11 80h ignored in mode", {7'd0, so_oe & so_out}, 8'h01);
        cs_n = 1'b1; tick(10);
        op1(8'h04);
        op1(8'h80);
        op1(8'h06);
        pgm_first(24'h000032, 8'h00, 8'h00);
        cs_n = 1'b0; tick(6);
        check("R11 disabled no level", {7'd0, so_oe}, 8'h00);
        cs_n = 1'b1; tick(10);
        status(v); check("R2 status while busy", v, 8'h43);
        wait_idle();
        op1(8'h04);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_no_wel();
        t_bad_length();
        t_first_and_next();
        t_and_program();
        t_busy_ignore();
        t_protect();
        t_boundary();
        t_ready_busy();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule